// File: doc/BRIEF.md
# SECDED Read Checker with Error Reporting

This block sits on the read path between an on-chip SRAM and the bus slave that serves it. Each memory word holds 32 data bits and 7 check bits. When checking is on, the block corrects any single flipped bit before the data reaches the bus. It detects double flips and passes the raw data through, raising an error response on the bus. When checking is off, the memory data is forwarded untouched.

For each detected error the block raises a one-cycle pulse, correctable or uncorrectable, that lines up with the read data. It also stores the address of the failing access and increments one of two saturating event counters. Bus reset clears the counters and the stored address. A separate clear input clears only the counters. The same path serves plain reads and the read half of a read-modify-write.

Top module: `secded_rd_check`

## Requirements
- R1: With checking on, a word with no flipped bit is returned unchanged on `rdata_o`, with `rdata_valid_o` high one clock after `rd_valid_i` and both error flags low.
- R2: With checking on, a single flipped data bit is corrected on `rdata_o`. `err_single_o` pulses and `bus_err_o` stays low.
- R3: With checking on, a single flipped check bit (word bits 37..32) or overall parity bit (bit 38) leaves the data unchanged and pulses `err_single_o` without `bus_err_o`.
- R4: With checking on, two flipped bits give the raw data bits 31..0 on `rdata_o`, and `err_double_o` and `bus_err_o` are high together.
- R5: With `ecc_en_i` low, `rdata_o` equals word bits 31..0. No flag rises, and neither counter nor the failing address changes.
- R6: Word layout: bits 31..0 hold data, and bits 37..32 hold Hamming check bits c0..c5. Data bit i takes the i-th position, in ascending order, among the integers from 3 upward that are not powers of two. Check bit ck is the XOR of the data bits whose position has bit k set. Bit 38 makes the XOR of all 39 bits zero.
- R7: Every detected error loads `fail_addr_o` with that read's `rd_addr_i`, visible with the flag. Reads without an error leave it unchanged.
- R8: `single_cnt_o` and `double_cnt_o` each rise by one per event of their own kind, visible in the same cycle as the flag.
- R9: Each counter saturates at all ones and holds there.
- R10: `cnt_clr_i` zeroes both counters on the next clock, taking priority over a simultaneous increment. It leaves `fail_addr_o` alone.
- R11: While `rst_ni` is low, all outputs, both counters and the failing address are zero.
- R12: Error flags are single-cycle pulses, high only together with `rdata_valid_o`. Back-to-back reads each give their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| ecc_en_i | input | 1 | Checking enable |
| rd_valid_i | input | 1 | Memory read word valid this cycle |
| rd_addr_i | input | ADDR_W | Address of the read |
| rd_word_i | input | 39 | Stored word: data, check bits, overall parity |
| cnt_clr_i | input | 1 | Clear both error counters |
| rdata_o | output | 32 | Bus read data |
| rdata_valid_o | output | 1 | Read data valid |
| err_single_o | output | 1 | Correctable error pulse |
| err_double_o | output | 1 | Uncorrectable error pulse |
| bus_err_o | output | 1 | Bus error response |
| fail_addr_o | output | ADDR_W | Address of the most recent error |
| single_cnt_o | output | CNT_W | Correctable error count |
| double_cnt_o | output | CNT_W | Uncorrectable error count |

## Verification
Stored words are encoded from the layout rule and then given chosen bit flips. A clean word shows the syndrome logic raises nothing. Flips at data bits 0, 13 and 31 test that correction picks the right position across the word. Flips in the check and parity bits separate check-bit errors from data errors. Flip pairs, one of them including the parity bit, separate double detection from miscorrection. The same flipped words sent with checking off show that bypass reports nothing. Bursts of errors then drive each counter into saturation and test clear priority and address capture.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HAM_W  = 6;
  localparam int unsigned WORD_W = DATA_W + HAM_W + 1;

  // Hamming position of data bit idx: idx-th non-power-of-two from 3 upward
  function automatic logic [HAM_W-1:0] data_pos(input int unsigned idx);
    int unsigned n;
    logic [HAM_W-1:0] p;
    n = 0;
    p = '0;
    for (int unsigned q = 3; q < 64; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == idx) p = HAM_W'(q);
        n++;
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/secded_decode.sv
module secded_decode
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W:0]    chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  localparam logic [HAM_W-1:0] MAX_POS = HAM_W'(DATA_W + HAM_W);

  logic [HAM_W-1:0] contrib [DATA_W];
  logic [HAM_W-1:0] syn;
  logic             odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [HAM_W-1:0] P = data_pos(i);
    assign contrib[i] = data_i[i] ? P : '0;
    assign data_o[i]  = data_i[i] ^ (single_o && (syn == P));
  end

  always_comb begin
    syn = chk_i[HAM_W-1:0];
    for (int i = 0; i < DATA_W; i++) syn ^= contrib[i];
  end

  assign odd      = ^{chk_i, data_i};
  assign single_o = odd && (syn <= MAX_POS);
  assign double_o = (!odd && (syn != '0)) || (odd && (syn > MAX_POS));
endmodule

// File: rtl/secded_err_cnt.sv
module secded_err_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX && !clr_i |=> cnt_q == CNT_MAX);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/secded_rd_check.sv
module secded_rd_check
  import secded_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_en_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic              cnt_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              err_single_o,
  output logic              err_double_o,
  output logic              bus_err_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [CNT_W-1:0]  single_cnt_o,
  output logic [CNT_W-1:0]  double_cnt_o
);
  logic [DATA_W-1:0] fixed_data;
  logic              dec_single, dec_double;
  logic              hit_single, hit_double;

  logic              valid_q, single_q, double_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] fail_addr_q;

  secded_decode i_decode (
    .data_i   (rd_word_i[DATA_W-1:0]),
    .chk_i    (rd_word_i[WORD_W-1:DATA_W]),
    .data_o   (fixed_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  assign hit_single = rd_valid_i && ecc_en_i && dec_single;
  assign hit_double = rd_valid_i && ecc_en_i && dec_double;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      single_q    <= 1'b0;
      double_q    <= 1'b0;
      rdata_q     <= '0;
      fail_addr_q <= '0;
    end else begin
      valid_q  <= rd_valid_i;
      single_q <= hit_single;
      double_q <= hit_double;
      // double keeps raw data; single is corrected
      if (rd_valid_i)
        rdata_q <= (ecc_en_i && !dec_double) ? fixed_data : rd_word_i[DATA_W-1:0];
      if (hit_single || hit_double) fail_addr_q <= rd_addr_i;
    end
  end

  secded_err_cnt #(.CNT_W(CNT_W)) i_cnt_single (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hit_single),
    .clr_i  (cnt_clr_i),
    .cnt_o  (single_cnt_o)
  );

  secded_err_cnt #(.CNT_W(CNT_W)) i_cnt_double (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hit_double),
    .clr_i  (cnt_clr_i),
    .cnt_o  (double_cnt_o)
  );

  assign rdata_o       = rdata_q;
  assign rdata_valid_o = valid_q;
  assign err_single_o  = single_q;
  assign err_double_o  = double_q;
  assign bus_err_o     = double_q;
  assign fail_addr_o   = fail_addr_q;

  a_r5_bypass_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && !ecc_en_i |=> !err_single_o && !err_double_o
      && rdata_o == $past(rd_word_i[DATA_W-1:0]) && $stable(fail_addr_o));
  a_r7_addr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && ecc_en_i && (dec_single || dec_double)
      |=> fail_addr_o == $past(rd_addr_i));
  a_r12_flag_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_single_o || err_double_o) |-> rdata_valid_o);
  a_r2_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_single_o && err_double_o));
  a_r4_resp_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && ecc_en_i && dec_double |=> bus_err_o && rdata_o == $past(rd_word_i[DATA_W-1:0]));
endmodule

// File: tb/test_secded_rd_check.sv
module test_secded_rd_check;
  localparam int AW = 12;
  localparam int CW = 3;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ecc_en = 1'b1;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [38:0]   rd_word = '0;
  logic          cnt_clr = 1'b0;
  logic [31:0]   rdata;
  logic          rvalid, e1, e2, berr;
  logic [AW-1:0] faddr;
  logic [CW-1:0] c1, c2;

  int total = 0;
  int bad = 0;

  logic [34:0] exp_q[$];  // {double, single, data}
  string       req_q[$];
  logic [CW-1:0] m_c1 = '0, m_c2 = '0;
  logic [AW-1:0] m_addr = '0;

  always #10 clk = ~clk;

  secded_rd_check #(.ADDR_W(AW), .CNT_W(CW)) i_secded_rd_check (
    .clk_i(clk), .rst_ni(rst_ni), .ecc_en_i(ecc_en), .rd_valid_i(rd_valid),
    .rd_addr_i(rd_addr), .rd_word_i(rd_word), .cnt_clr_i(cnt_clr),
    .rdata_o(rdata), .rdata_valid_o(rvalid), .err_single_o(e1), .err_double_o(e2),
    .bus_err_o(berr), .fail_addr_o(faddr), .single_cnt_o(c1), .double_cnt_o(c2)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R6 encoder, written from the layout rule
  function automatic logic [38:0] encode(input logic [31:0] d);
    logic [5:0] c;
    int unsigned pos;
    int unsigned i;
    c = '0;
    i = 0;
    pos = 2;
    while (i < 32) begin
      pos++;
      if ($countones(pos) != 1) begin
        for (int k = 0; k < 6; k++) if (pos[k] && d[i]) c[k] = ~c[k];
        i++;
      end
    end
    return {^{c, d}, c, d};
  endfunction

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] d, input logic [38:0] flips,
                    input logic en, input string req);
    logic [38:0] w;
    int n;
    logic s1, s2;
    w  = encode(d) ^ flips;
    n  = $countones(flips);
    s1 = en && n == 1;
    s2 = en && n == 2;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_word = w; ecc_en = en;
    exp_q.push_back({s2, s1, (en && n <= 1) ? d : w[31:0]});
    req_q.push_back(req);
    if (cnt_clr) begin
      m_c1 = '0; m_c2 = '0;
    end else begin
      if (s1 && m_c1 != CMAX) m_c1++;
      if (s2 && m_c2 != CMAX) m_c2++;
    end
    if (s1 || s2) m_addr = a;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rd_valid = 1'b0; cnt_clr = 1'b0;
    end
  endtask

  task automatic check_state(input string req);
    check({req, " single count"}, 64'(c1), 64'(m_c1));
    check({req, " double count"}, 64'(c2), 64'(m_c2));
    check({req, " fail addr"}, 64'(faddr), 64'(m_addr));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rvalid) begin
        if (exp_q.size() == 0) begin
          check("R12 unexpected valid", 64'(1), 64'(0));
        end else begin
          logic [34:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check({r, " data"}, 64'(rdata), 64'(e[31:0]));
          check({r, " single flag"}, 64'(e1), 64'(e[32]));
          check({r, " double flag"}, 64'(e2), 64'(e[33]));
          check({r, " bus error"}, 64'(berr), 64'(e[33]));
        end
      end else if (e1 || e2) begin
        check("R12 flag without valid", 64'({e1, e2}), 64'(0));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 valid", 64'(rvalid), 64'(0));
    check("R11 flags", 64'({e1, e2, berr}), 64'(0));
    check("R11 data", 64'(rdata), 64'(0));
    check_state("R11");
    @(negedge clk) rst_ni = 1'b1;

    // R1 clean
    rd(12'h001, 32'h0000_0000, '0, 1'b1, "R1 clean zero");
    rd(12'h002, 32'hFFFF_FFFF, '0, 1'b1, "R1 clean ones");
    rd(12'h003, 32'hA5A5_5A5A, '0, 1'b1, "R1 clean mix");
    idle(3);
    check_state("R1");

    // R2 single data flips
    rd(12'h010, 32'h1234_5678, 39'd1 << 0, 1'b1, "R2 flip d0");
    rd(12'h011, 32'hDEAD_BEEF, 39'd1 << 13, 1'b1, "R2 flip d13");
    rd(12'h012, 32'h0F0F_00FF, 39'd1 << 31, 1'b1, "R2 flip d31");
    idle(3);
    check_state("R2");

    // R3 check / parity bit flips
    rd(12'h020, 32'hCAFE_F00D, 39'd1 << 32, 1'b1, "R3 flip c0");
    rd(12'h021, 32'h8000_0001, 39'd1 << 37, 1'b1, "R3 flip c5");
    rd(12'h022, 32'h7777_1111, 39'd1 << 38, 1'b1, "R3 flip parity");
    idle(3);
    check_state("R3");

    // R4 double flips
    rd(12'h030, 32'h1357_9BDF, (39'd1 << 0) | (39'd1 << 1), 1'b1, "R4 flip d0 d1");
    rd(12'h031, 32'h2468_ACE0, (39'd1 << 5) | (39'd1 << 35), 1'b1, "R4 flip d5 c3");
    rd(12'h032, 32'hFFFF_0000, (39'd1 << 31) | (39'd1 << 38), 1'b1, "R4 flip d31 par");
    idle(3);
    check_state("R4 R7 R8");

    // R5 bypass with flipped words
    rd(12'h040, 32'h0BAD_C0DE, 39'd1 << 7, 1'b0, "R5 bypass single");
    rd(12'h041, 32'h0BAD_C0DE, (39'd1 << 2) | (39'd1 << 9), 1'b0, "R5 bypass double");
    idle(3);
    check_state("R5");

    // R12 back-to-back mixed
    rd(12'h050, 32'h5555_AAAA, '0, 1'b1, "R12 b2b clean");
    rd(12'h051, 32'h5555_AAAA, 39'd1 << 20, 1'b1, "R12 b2b single");
    rd(12'h052, 32'h5555_AAAA, (39'd1 << 3) | (39'd1 << 4), 1'b1, "R12 b2b double");
    rd(12'h053, 32'h5555_AAAA, '0, 1'b1, "R12 b2b clean2");
    idle(3);
    check_state("R12 R7");

    // R9 saturation of both counters
    for (int i = 0; i < 9; i++) rd(12'h100 + 12'(i), 32'(i * 7919), 39'd1 << (i * 3), 1'b1, "R9 sat single");
    for (int i = 0; i < 9; i++) rd(12'h200 + 12'(i), 32'(i * 104729), 39'd3 << i, 1'b1, "R9 sat double");
    idle(3);
    check("R9 single saturated", 64'(c1), 64'(CMAX));
    check("R9 double saturated", 64'(c2), 64'(CMAX));
    check_state("R9");

    // R10 clear with simultaneous single error
    cnt_clr = 1'b1;
    rd(12'h3A5, 32'h0000_1000, 39'd1 << 12, 1'b1, "R10 clear race");
    idle(3);
    check("R10 single cleared", 64'(c1), 64'(0));
    check("R10 double cleared", 64'(c2), 64'(0));
    check("R10 addr kept", 64'(faddr), 64'(12'h3A5));
    rd(12'h3A6, 32'h0000_2000, 39'd1 << 1, 1'b1, "R10 count after clear");
    idle(3);
    check_state("R10 R8");

    // R11 reset mid-run
    @(negedge clk) rst_ni = 1'b0;
    m_c1 = '0; m_c2 = '0; m_addr = '0;
    @(negedge clk);
    check("R11 valid again", 64'(rvalid), 64'(0));
    check_state("R11 again");
    rst_ni = 1'b1;
    idle(2);
    check("R12 scoreboard drained", 64'(exp_q.size()), 64'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule